// File: doc/BRIEF.md
# SMBus Word-Protocol Register Slave

This block is a bus slave for a two-wire system-management bus. It answers one fixed 7-bit address, 1110001b. It takes write-word transfers that carry a three-bit operation in the top of the command byte. It also serves a read-word transfer that returns two 5-bit code registers. The raw SCL and SDA levels are resynchronised to the system clock, and all bus events are found by comparing successive synchronised samples. SDA is driven through an active-high pull-low enable. The pad logic outside the block turns that enable into an open-drain output.

Three operations are recognised: setup, on and off. A setup transfer loads the two code registers, but only when the control block's write qualifier is high at the end of the transfer. The on and off transfers only signal the control block. Each completed write word raises one single-cycle event for its operation. A read-back transfer returns each register together with a status bit that the control block supplies, followed by two zero bits.

The controller is a five-state machine:
- **IDLE** waits for a start.
- **RX** shifts in a byte on SCL rising edges.
- **ACK** drives the acknowledge bit.
- **TX** shifts out read data on SCL falling edges.
- **AIN** samples the host's acknowledge.

A phase register records which byte of the transfer is in progress.

The transitions are:
- A start in any state goes to RX for the address.
- A stop in any state goes to IDLE.
- RX goes to ACK when a byte is complete and is accepted. It goes to IDLE when the byte is refused.
- ACK goes to RX (for the command or a data byte), to TX (for read data) or to IDLE (after the final data byte, or after a read-back command while armed for a repeated start).
- TX goes to AIN after eight bits.
- AIN goes back to TX when the host acknowledges the low byte. Otherwise it goes to IDLE.

Top module: `smb_word_slave`

## Requirements
- R1: After reset, `sda_pull` is 0, both code registers read 11111b and no event is raised.
- R2: An address byte is acknowledged (SDA pulled low during the ninth clock) only if its upper seven bits equal 1110001b and its last bit is 0 (write), or that bit is 1 (read) right after a read-back command. Any other address is not acknowledged, and the slave ignores the bus until the next start.
- R3: Bits [7:5] of the command byte select the operation: 000 on, 011 off, 001 setup, 010 read-back. The low five command bits are ignored. Any other operation value is not acknowledged, and the transfer is dropped.
- R4: In a write word, the address, the command and both data bytes are acknowledged. For setup with `wr_allow` high, data-low bits [7:3] become `code0` and data-high bits [7:3] become `code1`.
- R5: A setup transfer that ends with `wr_allow` low is fully acknowledged and leaves both code registers unchanged.
- R6: At the end of the final data acknowledge, exactly one of `ev_setup`, `ev_on`, `ev_off` pulses for one cycle, matching the operation. The data bytes of on and off are discarded.
- R7: In a read word (read-back command, repeated start, address with R/W=1), the slave sends {code0, conv_stat, 00}. On a host acknowledge it then sends {code1, conv_stat, 00}. Bytes go MSB first, and each bit changes after an SCL falling edge. After a host not-acknowledge it releases SDA and goes idle.
- R8: A read address that does not directly follow a read-back command (for example after an intervening stop) is not acknowledged.
- R9: A start in the middle of a transfer aborts it, commits no code data, raises no event and restarts address reception.
- R10: A stop in any state releases SDA and returns the slave to idle, and a following transfer is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level from the bus |
| sda_in | input | 1 | Raw SDA level from the bus |
| sda_pull | output | 1 | 1 = pull SDA low |
| wr_allow | input | 1 | Control-block qualifier permitting setup data to be committed |
| conv_stat | input | 1 | Status bit placed after the code in read-back bytes |
| ev_setup | output | 1 | One-cycle pulse: setup transfer completed |
| ev_on | output | 1 | One-cycle pulse: on transfer completed |
| ev_off | output | 1 | One-cycle pulse: off transfer completed |
| code0 | output | 5 | Code register 0 |
| code1 | output | 5 | Code register 1 |

## Verification
The hardest situation to reach from the ports is a start condition that arrives partway through a data byte. It only happens when the host breaks off its own bit sequence with SDA released during an SCL low phase, and the slave must then drop the buffered data-low code. The bench reaches it by sending a setup header and a complete data-low byte, clocking three bits of data-high, and then issuing a start. It then shows that the registers and event counts are untouched and that a new address is acknowledged. A second awkward case is the read arming. The bench separates a read-back command from its read address with a stop and confirms the read address is then refused.

// File: rtl/smbw_pkg.sv
package smbw_pkg;
    localparam int BYTE_W = 8;
    localparam int OP_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_AIN
    } state_e;

    typedef enum logic [2:0] {
        PH_ADDR,
        PH_CMD,
        PH_DLO,
        PH_DHI,
        PH_FIN,
        PH_RDARM,
        PH_RDLO,
        PH_RDHI
    } phase_e;

    localparam logic [OP_W-1:0] OP_ON    = 3'b000;
    localparam logic [OP_W-1:0] OP_SETUP = 3'b001;
    localparam logic [OP_W-1:0] OP_RDBK  = 3'b010;
    localparam logic [OP_W-1:0] OP_OFF   = 3'b011;
endpackage

// File: rtl/smbw_sync.sv
module smbw_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/smbw_cond.sv
module smbw_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smbw_codes.sv
module smbw_codes #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [CODE_W-1:0] new0,
    input  logic [CODE_W-1:0] new1,
    output logic [CODE_W-1:0] code0,
    output logic [CODE_W-1:0] code1
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code0 <= '1;
            code1 <= '1;
        end else if (commit) begin
            code0 <= new0;
            code1 <= new1;
        end
    end

    // R5 / R9: registers move only on a commit
    a_r5_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(code0) && $stable(code1)));
endmodule

// File: rtl/smb_word_slave.sv
module smb_word_slave
    import smbw_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'b1110001,
    parameter int         CODE_W      = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic              wr_allow,
    input  logic              conv_stat,
    output logic              ev_setup,
    output logic              ev_on,
    output logic              ev_off,
    output logic [CODE_W-1:0] code0,
    output logic [CODE_W-1:0] code1
);
    localparam int ADDR_W = BYTE_W - 1;
    localparam int PAD_W  = BYTE_W - CODE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    smbw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({scl_in, sda_in}), .q({scl_s, sda_s})
    );

    smbw_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    state_e state_q, state_d;
    phase_e phase_q, phase_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BYTE_W-1:0] sh_q, sh_d;
    logic [OP_W-1:0]   op_q, op_d;
    logic [CODE_W-1:0] lo_q, lo_d;
    logic pull_q, pull_d, armed_q, armed_d, hack_q, hack_d;
    logic [2:0] ev_q, ev_d;
    logic commit;
    logic [BYTE_W-1:0] rd_lo, rd_hi;

    assign rd_lo = {code0, conv_stat, {PAD_W{1'b0}}};
    assign rd_hi = {code1, conv_stat, {PAD_W{1'b0}}};

    smbw_codes #(.CODE_W(CODE_W)) u_codes (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .new0(lo_q), .new1(sh_q[BYTE_W-1 -: CODE_W]),
        .code0(code0), .code1(code1)
    );

    // next-state and datapath decisions
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        op_d    = op_q;
        lo_d    = lo_q;
        pull_d  = pull_q;
        armed_d = armed_q;
        hack_d  = hack_q;
        ev_d    = '0;
        commit  = 1'b0;
        if (stop_det) begin
            state_d = ST_IDLE;
            pull_d  = 1'b0;
            armed_d = 1'b0;
        end else if (start_det) begin
            state_d = ST_RX;
            phase_d = PH_ADDR;
            cnt_d   = '0;
            pull_d  = 1'b0;
            armed_d = (state_q == ST_IDLE) && armed_q;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_RX: begin
                    if (scl_rise) begin
                        sh_d  = {sh_q[BYTE_W-2:0], sda_s};
                        cnt_d = cnt_q + CNT_ONE;
                    end else if (scl_fall && cnt_q == CNT_FULL) begin
                        state_d = ST_ACK;
                        pull_d  = 1'b1;
                        case (phase_q)
                            PH_ADDR: begin
                                if (sh_q[BYTE_W-1 -: ADDR_W] == SLAVE_ADDR && !sh_q[0]) begin
                                    phase_d = PH_CMD;
                                    armed_d = 1'b0;
                                end else if (sh_q[BYTE_W-1 -: ADDR_W] == SLAVE_ADDR && armed_q) begin
                                    phase_d = PH_RDLO;
                                end else begin
                                    state_d = ST_IDLE;
                                    pull_d  = 1'b0;
                                    armed_d = 1'b0;
                                end
                            end
                            PH_CMD: begin
                                op_d = sh_q[BYTE_W-1 -: OP_W];
                                case (sh_q[BYTE_W-1 -: OP_W])
                                    OP_ON, OP_OFF, OP_SETUP: phase_d = PH_DLO;
                                    OP_RDBK:                 phase_d = PH_RDARM;
                                    default: begin
                                        state_d = ST_IDLE;
                                        pull_d  = 1'b0;
                                    end
                                endcase
                            end
                            PH_DLO: begin
                                lo_d    = sh_q[BYTE_W-1 -: CODE_W];
                                phase_d = PH_DHI;
                            end
                            default: phase_d = PH_FIN;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        pull_d = 1'b0;
                        case (phase_q)
                            PH_FIN: begin
                                state_d = ST_IDLE;
                                case (op_q)
                                    OP_SETUP: begin
                                        ev_d   = 3'b100;
                                        commit = wr_allow;
                                    end
                                    OP_ON:   ev_d = 3'b010;
                                    OP_OFF:  ev_d = 3'b001;
                                    default: ev_d = 3'b000;
                                endcase
                            end
                            PH_RDARM: begin
                                state_d = ST_IDLE;
                                armed_d = 1'b1;
                            end
                            PH_RDLO: begin
                                state_d = ST_TX;
                                armed_d = 1'b0;
                                sh_d    = rd_lo;
                                pull_d  = ~rd_lo[BYTE_W-1];
                                cnt_d   = CNT_ONE;
                            end
                            default: begin
                                state_d = ST_RX;
                                cnt_d   = '0;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt_q == CNT_FULL) begin
                            state_d = ST_AIN;
                            pull_d  = 1'b0;
                        end else begin
                            pull_d = ~sh_q[BYTE_W-2];
                            sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
                            cnt_d  = cnt_q + CNT_ONE;
                        end
                    end
                end
                ST_AIN: begin
                    if (scl_rise) begin
                        hack_d = ~sda_s;
                    end else if (scl_fall) begin
                        if (phase_q == PH_RDLO && hack_q) begin
                            state_d = ST_TX;
                            phase_d = PH_RDHI;
                            sh_d    = rd_hi;
                            pull_d  = ~rd_hi[BYTE_W-1];
                            cnt_d   = CNT_ONE;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_ADDR;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            op_q    <= '0;
            lo_q    <= '0;
            pull_q  <= 1'b0;
            armed_q <= 1'b0;
            hack_q  <= 1'b0;
            ev_q    <= '0;
        end else begin
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            op_q    <= op_d;
            lo_q    <= lo_d;
            pull_q  <= pull_d;
            armed_q <= armed_d;
            hack_q  <= hack_d;
            ev_q    <= ev_d;
        end
    end

    assign sda_pull = pull_q;
    assign ev_setup = ev_q[2];
    assign ev_on    = ev_q[1];
    assign ev_off   = ev_q[0];

    // R2 / R7: SDA is only driven while acknowledging or sending data
    a_r2_pull_only_drive: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (state_q == ST_ACK || state_q == ST_TX));

    // R10: a stop releases the line and idles the controller
    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE && !sda_pull));

    // R9: a start always restarts address reception from bit zero
    a_r9_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_RX && phase_q == PH_ADDR && cnt_q == '0));

    // R6: at most one event per cycle, raised as the controller idles
    a_r6_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_setup, ev_on, ev_off}));

    a_r6_event_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_setup || ev_on || ev_off) |-> state_q == ST_IDLE);
endmodule

// File: tb/smb_word_slave_test.sv
module smb_word_slave_test;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_scl = 1'b1, h_sda = 1'b1;
    logic wr_allow = 1'b1, conv_stat = 1'b0;
    logic sda_pull, ev_setup, ev_on, ev_off;
    logic [4:0] code0, code1;
    logic sda_line;

    int n_chk = 0, n_fail = 0;
    int cnt_s = 0, cnt_on = 0, cnt_off = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = h_sda & ~sda_pull;

    smb_word_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(h_scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .wr_allow(wr_allow), .conv_stat(conv_stat),
        .ev_setup(ev_setup), .ev_on(ev_on), .ev_off(ev_off),
        .code0(code0), .code1(code1)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (ev_setup) cnt_s++;
            if (ev_on)    cnt_on++;
            if (ev_off)   cnt_off++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        h_sda = 1'b1; tick();
        h_scl = 1'b1; tick();
        h_sda = 1'b0; tick();
        h_scl = 1'b0; tick();
    endtask

    task automatic bus_stop();
        h_sda = 1'b0; tick();
        h_scl = 1'b1; tick();
        h_sda = 1'b1; tick();
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        h_sda = b; tick();
        h_scl = 1'b1; tick();
        seen = sda_line;
        h_scl = 1'b0; tick();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic d;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], d);
        clk_bit(1'b1, d);
        acked = ~d;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic d;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, d);
            b[i] = d;
        end
        clk_bit(~give_ack, d);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // addr, cmd, dlo, dhi, wr_allow, addr ack, cmd ack, code0, code1, {setup,on,off}
    localparam logic [47:0] VEC [10] = '{
        {8'hE2, 8'h20, 8'h48, 8'h58, 1'b1, 1'b1, 1'b1, 5'd9,  5'd11, 3'b100},
        {8'hE4, 8'h20, 8'hF8, 8'hF8, 1'b1, 1'b0, 1'b0, 5'd9,  5'd11, 3'b000},
        {8'hE2, 8'h1F, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b1, 5'd9,  5'd11, 3'b010},
        {8'hE2, 8'h7A, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 5'd9,  5'd11, 3'b001},
        {8'hE2, 8'h3C, 8'h10, 8'hE7, 1'b0, 1'b1, 1'b1, 5'd9,  5'd11, 3'b100},
        {8'hE2, 8'h80, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 5'd9,  5'd11, 3'b000},
        {8'hE2, 8'hE0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 5'd9,  5'd11, 3'b000},
        {8'hE2, 8'h20, 8'h07, 8'hFF, 1'b1, 1'b1, 1'b1, 5'd0,  5'd31, 3'b100},
        {8'hE2, 8'h3F, 8'hA9, 8'h3E, 1'b1, 1'b1, 1'b1, 5'd21, 5'd7,  3'b100},
        {8'hE3, 8'h40, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 5'd21, 5'd7,  3'b000}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] b;
        int s0, o0, f0;

        repeat (4) @(negedge clk);
        // R1 reset state
        chk(sda_pull == 1'b0, "R1 sda released in reset", sda_pull, 0);
        chk(code0 == 5'h1F, "R1 code0 reset", code0, 5'h1F);
        chk(code1 == 5'h1F, "R1 code1 reset", code1, 5'h1F);
        rst_n = 1'b1;
        tick();
        chk(sda_pull == 1'b0 && cnt_s + cnt_on + cnt_off == 0, "R1 idle after reset", sda_pull, 0);

        // table-driven write-word vectors (R2 R3 R4 R5 R6)
        for (int v = 0; v < 10; v++) begin
            logic [47:0] e;
            e = VEC[v];
            s0 = cnt_s; o0 = cnt_on; f0 = cnt_off;
            wr_allow = e[15];
            bus_start();
            send_byte(e[47:40], a);
            chk(a == e[14], $sformatf("R2 vec%0d address ack", v), a, e[14]);
            if (a) begin
                send_byte(e[39:32], a);
                chk(a == e[13], $sformatf("R3 vec%0d command ack", v), a, e[13]);
                if (a) begin
                    send_byte(e[31:24], a);
                    chk(a, $sformatf("R4 vec%0d data-low ack", v), a, 1);
                    send_byte(e[23:16], a);
                    chk(a, $sformatf("R4 vec%0d data-high ack", v), a, 1);
                end
            end
            bus_stop();
            tick();
            chk(code0 == e[12:8], $sformatf("R4 R5 vec%0d code0", v), code0, e[12:8]);
            chk(code1 == e[7:3], $sformatf("R4 R5 vec%0d code1", v), code1, e[7:3]);
            chk({cnt_s - s0 == 1, cnt_on - o0 == 1, cnt_off - f0 == 1} == e[2:0]
                && (cnt_s - s0) + (cnt_on - o0) + (cnt_off - f0) <= 1,
                $sformatf("R6 vec%0d events", v),
                {cnt_s - s0, cnt_on - o0, cnt_off - f0}, e[2:0]);
        end
        wr_allow = 1'b1;

        // R7 read word with both bytes, status 1
        conv_stat = 1'b1;
        bus_start();
        send_byte(8'hE2, a); chk(a, "R7 read: write address ack", a, 1);
        send_byte(8'h40, a); chk(a, "R7 read: read-back command ack", a, 1);
        bus_start();
        send_byte(8'hE3, a); chk(a, "R7 read: read address ack", a, 1);
        recv_byte(1'b1, b); chk(b == 8'hAC, "R7 read: low byte", b, 8'hAC);
        recv_byte(1'b0, b); chk(b == 8'h3C, "R7 read: high byte", b, 8'h3C);
        tick();
        chk(sda_line == 1'b1, "R7 SDA released after nack", sda_line, 1);
        bus_stop();

        // R7 host nack on first byte, status 0
        conv_stat = 1'b0;
        bus_start();
        send_byte(8'hE2, a);
        send_byte(8'h40, a);
        bus_start();
        send_byte(8'hE3, a); chk(a, "R7 read2: read address ack", a, 1);
        recv_byte(1'b0, b); chk(b == 8'hA8, "R7 read2: low byte status 0", b, 8'hA8);
        tick();
        chk(sda_line == 1'b1, "R7 SDA released after early nack", sda_line, 1);
        bus_stop();

        // R8 stop between read-back command and read address
        bus_start();
        send_byte(8'hE2, a);
        send_byte(8'h40, a);
        bus_stop();
        bus_start();
        send_byte(8'hE3, a); chk(!a, "R8 read address refused after stop", a, 0);
        bus_stop();

        // R9 start inside data-high byte
        s0 = cnt_s; o0 = cnt_on; f0 = cnt_off;
        bus_start();
        send_byte(8'hE2, a);
        send_byte(8'h20, a);
        send_byte(8'h00, a); chk(a, "R9 data-low ack before abort", a, 1);
        clk_bit(1'b1, a); clk_bit(1'b1, a); clk_bit(1'b1, a);
        bus_start();
        send_byte(8'hE2, a); chk(a, "R9 address ack after abort", a, 1);
        // R10 stop after address phase
        bus_stop();
        tick();
        chk(sda_line == 1'b1, "R10 SDA released after stop", sda_line, 1);
        chk(code0 == 5'd21 && code1 == 5'd7, "R9 no commit on abort", {code0, code1}, {5'd21, 5'd7});
        chk((cnt_s - s0) + (cnt_on - o0) + (cnt_off - f0) == 0, "R9 no event on abort",
            (cnt_s - s0) + (cnt_on - o0) + (cnt_off - f0), 0);

        // R10 a normal transfer after the interrupted ones
        bus_start();
        send_byte(8'hE2, a);
        send_byte(8'h20, a);
        send_byte(8'h50, a);
        send_byte(8'h60, a); chk(a, "R10 final ack of recovery transfer", a, 1);
        bus_stop();
        tick();
        chk(code0 == 5'd10 && code1 == 5'd12, "R10 recovery setup", {code0, code1}, {5'd10, 5'd12});

        // R1 reset restores the codes
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(code0 == 5'h1F && code1 == 5'h1F && sda_pull == 1'b0, "R1 reset mid-run",
            {code0, code1}, 10'h3FF);
        rst_n = 1'b1;
        tick();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule